// File: doc/BRIEF.md
# Printer Port Host Register Block

This block is the host-facing register file of a byte-wide printer port. It also contains a small behavioural model of the printer on the far side. The host uses a plain synchronous bus: one-cycle write and read strobes, a 3-bit register offset, and 8-bit write and read data. Three offsets are mapped: a data register, a status register and a control register. Reads of the status register have side effects: they clear a pending interrupt and step a simulated busy/acknowledge handshake.

Control writes carry most of the behaviour. With the init line low, a control write resets the printer status. With the printer selected, a rising strobe marks the printer busy and sends the latched data byte out on a byte output with a one-cycle valid pulse. A falling or held-low strobe raises an interrupt if interrupts were already enabled. The interrupt output is a level that follows an internal pending flag. The read-data latch samples an external byte input on every clock. The host sees that latch through the data offset when the direction bit selects input.

Read data is combinational from the current state while the read strobe is high. Side effects take hold at the clock edge that ends the access. A write and a read in the same cycle are not supported: the write takes effect and the read's side effects are dropped.

Top module: `lpt_host_regs`

## Requirements
- R1: Offset 0 is data, offset 1 is status and offset 2 is control. A read of offsets 3 to 7 returns 0xFF. A write to offsets 1 and 3 to 7 changes no register.
- R2: After reset, the data offset reads 0xFF, status reads 0xD9 and control reads 0xCC. The interrupt output and the byte-valid output are both 0.
- R3: A control write stores the written byte with bits 7 and 6 forced to 1, and control reads return that stored value.
- R4: A control write with bit 2 (init) at 0 sets status to 0xD8, whatever the other bits are.
- R5: A control write with bit 2 at 1, bit 3 (select) at 1 and bit 0 (strobe) at 1 clears status bit 7 (not-busy). If the stored control had strobe at 0, the written-data latch appears on the byte output with valid high for exactly one cycle after the write; otherwise valid stays 0.
- R6: A control write with bit 2 at 1, bit 3 at 1 and bit 0 at 0 makes the interrupt pending when the stored control had bit 4 (interrupt enable) set. The interrupt output equals the pending flag from the next cycle.
- R7: A status read returns the stored status and clears the pending interrupt.
- R8: On a status read where status bit 7 and control bit 0 are both 0, status bit 6 (acknowledge) is cleared if it was set; otherwise bits 7 and 6 are both set.
- R9: A data read returns the read-data latch when control bit 5 is 1, and the written-data latch when it is 0. The read-data latch captures the external input byte on every clock.
- R10: A control write with bit 2 at 1 and bit 3 at 0 changes neither status nor the interrupt, and emits no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data (valid while rd_en) |
| ext_data | input | 8 | Byte from the port pins, sampled every clock |
| out_byte | output | 8 | Byte sent to the printer |
| out_valid | output | 1 | One-cycle pulse when out_byte is new |
| irq | output | 1 | Level interrupt |

## Verification
The bench walks the full acknowledge/busy cycle, 0x59 to 0x19 to 0xD9, by repeated status polls. It also checks that polling with the strobe still high leaves the status frozen; a design that ignored the strobe term would step early. Repeated strobe-high writes must not emit a second byte, which catches an edge detector that uses the new control value instead of the stored one. The interrupt test uses the previous enable bit: a design that used the newly written enable would fire one write too early. Exhaustive sweeps cover all 256 control bytes for readback, all 256 data values, and every unmapped offset, for both reads and writes.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
    localparam int DW    = 8;
    localparam int OFF_W = 3;

    localparam logic [OFF_W-1:0] OFF_DATA   = 3'd0;
    localparam logic [OFF_W-1:0] OFF_STATUS = 3'd1;
    localparam logic [OFF_W-1:0] OFF_CTRL   = 3'd2;

    // status bit positions
    localparam int ST_NBUSY = 7;
    localparam int ST_ACK   = 6;
    // control bit positions
    localparam int CT_DIR  = 5;
    localparam int CT_IEN  = 4;
    localparam int CT_SEL  = 3;
    localparam int CT_INIT = 2;
    localparam int CT_STB  = 0;

    localparam logic [DW-1:0] ST_RESET  = 8'hD9;
    localparam logic [DW-1:0] ST_INITV  = 8'hD8;
    localparam logic [DW-1:0] CT_RESET  = 8'hCC;
    localparam logic [DW-1:0] CT_FORCE  = 8'hC0;
    localparam logic [DW-1:0] BUS_IDLE  = 8'hFF;

    typedef struct packed {
        logic [DW-1:0] dataw;
        logic [DW-1:0] datar;
        logic [DW-1:0] status;
        logic [DW-1:0] ctrl;
        logic          pend;
        logic [DW-1:0] obyte;
        logic          ovalid;
    } lpt_state_t;
endpackage

// File: rtl/lpt_ctrl_write.sv
module lpt_ctrl_write
    import lpt_pkg::*;
(
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] status_q,
    input  logic          prev_stb,
    input  logic          prev_ien,
    output logic [DW-1:0] ctrl_nx,
    output logic [DW-1:0] status_nx,
    output logic          emit,
    output logic          raise
);
    always_comb begin
        ctrl_nx   = wdata | CT_FORCE;
        status_nx = status_q;
        emit      = 1'b0;
        raise     = 1'b0;
        if (!ctrl_nx[CT_INIT]) begin
            status_nx = ST_INITV;
        end else if (ctrl_nx[CT_SEL]) begin
            if (ctrl_nx[CT_STB]) begin
                status_nx[ST_NBUSY] = 1'b0;
                emit = !prev_stb;
            end else begin
                raise = prev_ien;
            end
        end
    end
endmodule

// File: rtl/lpt_status_poll.sv
module lpt_status_poll
    import lpt_pkg::*;
(
    input  logic [DW-1:0] status_q,
    input  logic          stb,
    output logic [DW-1:0] status_nx
);
    always_comb begin
        status_nx = status_q;
        if (!status_q[ST_NBUSY] && !stb) begin
            if (status_q[ST_ACK]) begin
                status_nx[ST_ACK] = 1'b0;
            end else begin
                status_nx[ST_ACK]   = 1'b1;
                status_nx[ST_NBUSY] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/lpt_read_mux.sv
module lpt_read_mux
    import lpt_pkg::*;
(
    input  logic [OFF_W-1:0] off,
    input  logic             dir_in,
    input  logic [DW-1:0]    dataw,
    input  logic [DW-1:0]    datar,
    input  logic [DW-1:0]    status,
    input  logic [DW-1:0]    ctrl,
    output logic [DW-1:0]    rdata
);
    always_comb begin
        case (off)
            OFF_DATA:   rdata = dir_in ? datar : dataw;
            OFF_STATUS: rdata = status;
            OFF_CTRL:   rdata = ctrl;
            default:    rdata = BUS_IDLE;
        endcase
    end
endmodule

// File: rtl/lpt_host_regs.sv
module lpt_host_regs
    import lpt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [OFF_W-1:0] addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    input  logic [DW-1:0]    ext_data,
    output logic [DW-1:0]    out_byte,
    output logic             out_valid,
    output logic             irq
);
    lpt_state_t st_q, st_d;

    logic [DW-1:0] cw_ctrl, cw_status, poll_status;
    logic          cw_emit, cw_raise;

    lpt_ctrl_write u_cw (
        .wdata    (wdata),
        .status_q (st_q.status),
        .prev_stb (st_q.ctrl[CT_STB]),
        .prev_ien (st_q.ctrl[CT_IEN]),
        .ctrl_nx  (cw_ctrl),
        .status_nx(cw_status),
        .emit     (cw_emit),
        .raise    (cw_raise)
    );

    lpt_status_poll u_poll (
        .status_q (st_q.status),
        .stb      (st_q.ctrl[CT_STB]),
        .status_nx(poll_status)
    );

    lpt_read_mux u_rmux (
        .off   (addr),
        .dir_in(st_q.ctrl[CT_DIR]),
        .dataw (st_q.dataw),
        .datar (st_q.datar),
        .status(st_q.status),
        .ctrl  (st_q.ctrl),
        .rdata (rdata)
    );

    always_comb begin
        st_d        = st_q;
        st_d.ovalid = 1'b0;
        st_d.datar  = ext_data;
        if (wr_en) begin
            case (addr)
                OFF_DATA: st_d.dataw = wdata;
                OFF_CTRL: begin
                    st_d.ctrl   = cw_ctrl;
                    st_d.status = cw_status;
                    if (cw_emit) begin
                        st_d.obyte  = st_q.dataw;
                        st_d.ovalid = 1'b1;
                    end
                    if (cw_raise) st_d.pend = 1'b1;
                end
                default: ;
            endcase
        end else if (rd_en && addr == OFF_STATUS) begin
            st_d.pend   = 1'b0;
            st_d.status = poll_status;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.dataw  <= BUS_IDLE;
            st_q.datar  <= BUS_IDLE;
            st_q.status <= ST_RESET;
            st_q.ctrl   <= CT_RESET;
            st_q.pend   <= 1'b0;
            st_q.obyte  <= '0;
            st_q.ovalid <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_byte  = st_q.obyte;
    assign out_valid = st_q.ovalid;
    assign irq       = st_q.pend;

    assert_unmapped_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr > OFF_CTRL) |-> rdata == BUS_IDLE);
    assert_ctrl_forced_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ctrl[7:6] == 2'b11);
    assert_init_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_CTRL && !wdata[CT_INIT]) |=> st_q.status == ST_INITV);
    assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
    assert_emit_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> out_byte == $past(st_q.dataw));
    assert_irq_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr == OFF_STATUS) |=> !irq);
    assert_no_sel_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_CTRL && wdata[CT_INIT] && !wdata[CT_SEL])
        |=> ($stable(st_q.status) && !out_valid));
endmodule

// File: tb/lpt_host_regs_tb.sv
module lpt_host_regs_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0, ext_data = 8'h00;
    logic [7:0] rdata, out_byte;
    logic       out_valid, irq;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    lpt_host_regs u_dut (.*);

    always #2 clk = ~clk;

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a; #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(4ns * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2 reset values, R1 unmapped reads
        check("R2 irq", {7'd0, irq}, 8'h00);
        check("R2 valid", {7'd0, out_valid}, 8'h00);
        for (int o = 0; o < 8; o++) begin
            rd(3'(o), v);
            check("R2/R1 reset read", v,
                  o == 1 ? 8'hD9 : (o == 2 ? 8'hCC : 8'hFF));
        end
        // R9 direction 0 returns written latch
        wr(3'd0, 8'h5A);
        rd(3'd0, v); check("R9 dataw", v, 8'h5A);
        // R5 strobe rise emits
        wr(3'd2, 8'h0D);
        check("R5 valid", {7'd0, out_valid}, 8'h01);
        check("R5 byte", out_byte, 8'h5A);
        @(negedge clk);
        check("R5 pulse end", {7'd0, out_valid}, 8'h00);
        wr(3'd2, 8'h0D);
        check("R5 no re-emit", {7'd0, out_valid}, 8'h00);
        // R8 no advance while strobe high
        rd(3'd1, v); check("R7 status busy", v, 8'h59);
        rd(3'd1, v); check("R8 frozen stb", v, 8'h59);
        wr(3'd2, 8'h0C);
        check("R6 no ien", {7'd0, irq}, 8'h00);
        rd(3'd1, v); check("R8 poll1", v, 8'h59);
        rd(3'd1, v); check("R8 poll2", v, 8'h19);
        rd(3'd1, v); check("R8 poll3", v, 8'hD9);
        rd(3'd1, v); check("R8 idle", v, 8'hD9);
        // R6 interrupt uses previous enable
        wr(3'd2, 8'h1C);
        check("R6 first", {7'd0, irq}, 8'h00);
        wr(3'd2, 8'h1C);
        check("R6 raise", {7'd0, irq}, 8'h01);
        wr(3'd0, 8'h00);
        check("R6 hold", {7'd0, irq}, 8'h01);
        rd(3'd1, v); check("R7 value", v, 8'hD9);
        check("R7 clear", {7'd0, irq}, 8'h00);
        // R10 select low
        wr(3'd2, 8'h14);
        wr(3'd2, 8'h14);
        check("R10 irq", {7'd0, irq}, 8'h00);
        wr(3'd2, 8'h15);
        check("R10 emit", {7'd0, out_valid}, 8'h00);
        rd(3'd1, v); check("R10 status", v, 8'hD9);
        // R4 init low
        wr(3'd2, 8'h0C);
        wr(3'd2, 8'h0D);
        rd(3'd1, v); check("R5 busy clr", v, 8'h59);
        wr(3'd2, 8'h09);
        rd(3'd1, v); check("R4 init", v, 8'hD8);
        // R9 input direction
        ext_data = 8'hA3;
        wr(3'd2, 8'h2C);
        rd(3'd0, v); check("R9 ext1", v, 8'hA3);
        wr(3'd0, 8'h11);
        rd(3'd0, v); check("R9 ext hold", v, 8'hA3);
        ext_data = 8'h3C;
        @(negedge clk);
        rd(3'd0, v); check("R9 ext2", v, 8'h3C);
        wr(3'd2, 8'h0C);
        rd(3'd0, v); check("R9 back", v, 8'h11);
        // R1 writes to status and unmapped offsets ignored
        for (int o = 3; o < 8; o++) wr(3'(o), 8'h00);
        wr(3'd1, 8'h00);
        rd(3'd0, v); check("R1 data kept", v, 8'h11);
        rd(3'd2, v); check("R1 ctrl kept", v, 8'hCC);
        rd(3'd1, v); check("R1 status kept", v, 8'hD8);
        // R9 data sweep
        for (int i = 0; i < 256; i++) begin
            wr(3'd0, 8'(i));
            rd(3'd0, v); check("R9 sweep", v, 8'(i));
        end
        // R3 control sweep
        for (int i = 0; i < 256; i++) begin
            wr(3'd2, 8'(i));
            rd(3'd2, v); check("R3 sweep", v, 8'(i) | 8'hC0);
        end
        finish_run();
    end
endmodule